// File: doc/BRIEF.md
# Raster Coprocessor Program Loader

This block is the front end of a display coprocessor that runs in step with the raster. It takes register writes from the host processor or from the coprocessor itself. It turns them into writes to a 2K-byte instruction memory, which is organised as 1024 words of 16 bits. It also decides when the coprocessor runs and from which instruction it starts. Fetching, decoding and executing instructions happen in an external executor. That executor reads the program counter, and it advances the counter one instruction at a time with a step pulse.

An 11-bit byte pointer selects the memory location for the next write. Software loads the pointer through two registers. There are two data ports. The byte port writes one byte at the pointer. The pair port collects the even (high) byte and writes the whole 16-bit word when the odd (low) byte arrives. Both ports advance the pointer by one after each byte. A two-bit start field selects one of four modes: stopped, run from the start, resume where the counter stopped, or run from the start and restart at the top of every frame. Register writes that the coprocessor issues to indices 0x80 and above are held back from the rest of the register file.

Top module: `rcop_loader`

## Requirements
- R1: After reset the byte pointer is 0, the start field is 00, `run` is 0, `pc` is 0 and `mem_we` is 0.
- R2: A write to index 0x60 stores its byte at the pointer. In the next cycle `mem_we` is 1 and `mem_waddr` is pointer[10:1]. `mem_be` is 10 (upper byte) for an even pointer and 01 (lower byte) for an odd pointer, and both halves of `mem_wdata` carry the byte. The pointer then advances by one.
- R3: A write to index 0x63 at an even pointer only holds the byte, and `mem_we` stays 0. A write to index 0x63 at an odd pointer writes the word {held byte, new byte} with `mem_be` 11. Each write advances the pointer by one.
- R4: A write to index 0x61 loads pointer[7:0], and a write to index 0x62 loads pointer[10:8] from data bits 2:0. Reading index 0x61 returns pointer[7:0]. Reading index 0x62 returns {start field, 000, pointer[10:8]}. The pointer wraps from 0x7FF to 0.
- R5: Writing start field 01 or 11 (data bits 7:6) while it holds a different value sets `pc` to 0 and `run` to 1 in the next cycle.
- R6: Writing start field 10 while it holds a different value sets `run` to 1 and keeps `pc` unchanged.
- R7: With start field 00, `run` is 0 and `step` does not change `pc`.
- R8: Writing the start field with the value it already holds changes neither `pc` nor `run`.
- R9: While `run` is 1, each cycle with `step` high adds one to `pc`, and `pc` wraps from 1023 to 0.
- R10: In start field 11, a cycle with the raster at x=0 and y=0 sets `pc` to 0. In the other modes the raster position has no effect.
- R11: `pass_wr` follows `reg_wr`, except that it is 0 for a coprocessor-issued write (`reg_cop`=1) to an index with bit 7 set. A blocked write has no effect on this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_cop | input | 1 | The write comes from the coprocessor |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| rd_idx | input | 8 | Register index for readback |
| rd_data | output | 8 | Readback data (combinational) |
| pass_wr | output | 1 | Write strobe passed on to the rest of the register file |
| mem_we | output | 1 | Instruction memory write enable |
| mem_be | output | 2 | Byte enables: bit 1 upper, bit 0 lower |
| mem_waddr | output | 10 | Word address |
| mem_wdata | output | 16 | Word data |
| step | input | 1 | Executor advances the program counter |
| ras_x | input | 9 | Raster column |
| ras_y | input | 9 | Raster line |
| run | output | 1 | Coprocessor running |
| pc | output | 10 | Program counter (word index) |

## Verification
The loading path is driven with byte-port writes at even and odd pointers, at the top pointer 0x7FF (to show the wrap), and with pair-port sequences in which the even half must stay silent. Random mixes of the two ports also cover misaligned pair writes. Start-field writes cover every transition between the four modes and also repeats of the current mode. Repeats separate a restart from a no-op. A move from stopped to resume separates a kept counter from a cleared one. Raster-origin pulses are sent in each mode to show that only the frame-restart mode responds. Coprocessor writes above and below index 0x80 show the filter.

// File: rtl/rcop_loader.sv
module rcop_loader #(
  parameter int AW = 11,
  parameter int XW = 9,
  parameter int YW = 9,
  parameter logic [7:0] IDX_BYTE = 8'h60,
  parameter logic [7:0] IDX_ALO  = 8'h61,
  parameter logic [7:0] IDX_CTL  = 8'h62,
  parameter logic [7:0] IDX_PAIR = 8'h63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_cop,
  input  logic [7:0]    reg_idx,
  input  logic [7:0]    reg_wdata,
  input  logic [7:0]    rd_idx,
  output logic [7:0]    rd_data,
  output logic          pass_wr,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [AW-2:0] mem_waddr,
  output logic [15:0]   mem_wdata,
  input  logic          step,
  input  logic [XW-1:0] ras_x,
  input  logic [YW-1:0] ras_y,
  output logic          run,
  output logic [AW-2:0] pc
);
  localparam int HW = AW - 8;

  logic [AW-1:0] addr;
  logic [1:0]    mode;
  logic [7:0]    stage;

  wire wr_ok    = reg_wr && !(reg_cop && reg_idx[7]);
  wire w_byte   = wr_ok && (reg_idx == IDX_BYTE);
  wire w_alo    = wr_ok && (reg_idx == IDX_ALO);
  wire w_ctl    = wr_ok && (reg_idx == IDX_CTL);
  wire w_pair   = wr_ok && (reg_idx == IDX_PAIR);
  wire mode_chg = w_ctl && (reg_wdata[7:6] != mode);
  wire at_org   = (ras_x == '0) && (ras_y == '0);

  assign pass_wr = wr_ok;
  assign run     = (mode != 2'b00);

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx == IDX_ALO) rd_data = addr[7:0];
    else if (rd_idx == IDX_CTL) begin
      rd_data[7:6]    = mode;
      rd_data[HW-1:0] = addr[AW-1:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      mode  <= 2'b00;
      stage <= 8'h00;
    end else begin
      if (w_alo) addr[7:0] <= reg_wdata;
      else if (w_ctl) addr[AW-1:8] <= reg_wdata[HW-1:0];
      else if (w_byte || w_pair) addr <= addr + 1'b1;
      if (w_ctl) mode <= reg_wdata[7:6];
      if (w_pair && !addr[0]) stage <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_be    <= 2'b00;
      mem_waddr <= '0;
      mem_wdata <= 16'h0000;
    end else begin
      mem_we <= w_byte || (w_pair && addr[0]);
      if (w_byte) begin
        mem_waddr <= addr[AW-1:1];
        mem_be    <= addr[0] ? 2'b01 : 2'b10;
        mem_wdata <= {reg_wdata, reg_wdata};
      end else if (w_pair && addr[0]) begin
        mem_waddr <= addr[AW-1:1];
        mem_be    <= 2'b11;
        mem_wdata <= {stage, reg_wdata};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (mode_chg && reg_wdata[6]) pc <= '0;
    else if (mode == 2'b11 && at_org) pc <= '0;
    else if (run && step) pc <= pc + 1'b1;
  end

  // R2
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_byte |=> mem_we && $onehot(mem_be));

  // R3
  pair_even_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_pair && !addr[0]) |=> !mem_we);

  // R5
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && reg_wdata[6]) |=> (pc == '0) && run);

  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !w_ctl) |=> $stable(pc));

  // R9
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !w_ctl && !(mode == 2'b11 && at_org)) |=> pc == $past(pc) + 1'b1);

  // R11
  cop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cop && reg_idx[7]) |-> !pass_wr);
endmodule

// File: tb/rcop_loader_bench.sv
`timescale 1ns/1ps
module rcop_loader_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_cop = 0, step = 0;
  logic [7:0] reg_idx = 0, reg_wdata = 0, rd_idx = 0, rd_data;
  logic pass_wr, mem_we, run;
  logic [1:0] mem_be;
  logic [9:0] mem_waddr, pc;
  logic [15:0] mem_wdata;
  logic [8:0] ras_x = 9'd5, ras_y = 9'd5;

  rcop_loader u_rcop_loader (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_cop(reg_cop),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .rd_idx(rd_idx), .rd_data(rd_data),
    .pass_wr(pass_wr), .mem_we(mem_we), .mem_be(mem_be), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .step(step), .ras_x(ras_x), .ras_y(ras_y), .run(run), .pc(pc));

  always #5 clk = ~clk;

  int nvec = 0, nerr = 0;
  logic [10:0] m_addr = 0;
  logic [1:0]  m_mode = 0;
  logic [9:0]  m_pc = 0;
  logic [7:0]  m_stage = 0;

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctl_rd();
    return {m_mode, 3'b000, m_addr[10:8]};
  endfunction

  task automatic op(bit wr, logic [7:0] idx, logic [7:0] d, bit cop, bit stp, bit org);
    bit ok, ewe;
    logic [1:0] ebe;
    logic [9:0] ewa;
    logic [15:0] ewd;
    @(negedge clk);
    reg_wr = wr; reg_idx = idx; reg_wdata = d; reg_cop = cop; step = stp;
    if (org) begin ras_x = 0; ras_y = 0; end
    #1;
    ok = wr && !(cop && idx[7]);
    chk("R11 pass_wr", pass_wr, ok);
    ewe = 0; ebe = 0; ewa = m_addr[10:1]; ewd = 0;
    if (ok && idx == 8'h60) begin
      ewe = 1; ebe = m_addr[0] ? 2'b01 : 2'b10; ewd = {d, d};
      m_addr = m_addr + 1;
    end else if (ok && idx == 8'h63) begin
      if (m_addr[0]) begin ewe = 1; ebe = 2'b11; ewd = {m_stage, d}; end
      else m_stage = d;
      m_addr = m_addr + 1;
    end else if (ok && idx == 8'h61) m_addr[7:0] = d;
    if (ok && idx == 8'h62) begin
      m_addr[10:8] = d[2:0];
      if (d[7:6] != m_mode) begin
        if (d[6]) m_pc = 0;
        m_mode = d[7:6];
      end
    end else if (m_mode == 2'b11 && org) m_pc = 0;
    else if (m_mode != 0 && stp) m_pc = m_pc + 1;
    @(negedge clk);
    reg_wr = 0; step = 0; reg_cop = 0; ras_x = 5; ras_y = 5;
    #1;
    chk("R2/R3 mem_we", mem_we, ewe);
    if (ewe) begin
      chk("R2/R3 mem_be", mem_be, ebe);
      chk("R2/R3 mem_waddr", mem_waddr, ewa);
      chk("R2/R3 mem_wdata", mem_wdata, ewd);
    end
    chk("R5/R6/R9/R10 pc", pc, m_pc);
    chk("R7/R8 run", run, m_mode != 0);
    rd_idx = 8'h61; #1 chk("R4 rd lo", rd_data, m_addr[7:0]);
    rd_idx = 8'h62; #1 chk("R4 rd ctl", rd_data, exp_ctl_rd());
  endtask

  initial begin
    void'($urandom(32'd4242));
    #22 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 run", run, 0); chk("R1 pc", pc, 0); chk("R1 mem_we", mem_we, 0);
    rd_idx = 8'h62; #1 chk("R1 ctl", rd_data, 0);
    rd_idx = 8'h61; #1 chk("R1 lo", rd_data, 0);
    // R4 R2 top-of-memory byte write and wrap
    op(1, 8'h62, 8'h07, 0, 0, 0);
    op(1, 8'h61, 8'hFF, 0, 0, 0);
    op(1, 8'h60, 8'h5A, 0, 0, 0);
    chk("R4 wrap", m_addr, 0);
    op(1, 8'h60, 8'h33, 0, 0, 0);
    // R3 pair write
    op(1, 8'h61, 8'h10, 0, 0, 0);
    op(1, 8'h63, 8'hAB, 0, 0, 0);
    op(1, 8'h63, 8'hCD, 0, 0, 0);
    // R5 R9 R8
    op(1, 8'h62, 8'h40, 0, 0, 0);
    for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 1, 0);
    op(1, 8'h62, 8'h40, 0, 0, 0);
    // R7 stop then R6 resume
    op(1, 8'h62, 8'h00, 0, 0, 0);
    op(0, 0, 0, 0, 1, 0);
    op(1, 8'h62, 8'h80, 0, 0, 0);
    chk("R6 resume pc", pc, 3);
    // R10 origin ignored outside mode 11
    op(0, 0, 0, 0, 0, 1);
    // R9 wrap
    for (int i = 0; i < 1021; i++) op(0, 0, 0, 0, 1, 0);
    chk("R9 wrapped", pc, 0);
    op(0, 0, 0, 0, 1, 0);
    // R10 frame restart
    op(1, 8'h62, 8'hC0, 0, 0, 0);
    op(0, 0, 0, 0, 1, 0); op(0, 0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 0, 1);
    chk("R10 restart", pc, 0);
    // R11 coprocessor writes
    op(1, 8'h85, 8'h11, 1, 0, 0);
    op(1, 8'h62, 8'h40, 1, 0, 0);
    op(1, 8'h90, 8'h22, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 7);
      logic [7:0] d = 8'($urandom);
      bit c = 1'($urandom);
      case (k)
        0: op(1, 8'h60, d, c, 0, 0);
        1: op(1, 8'h63, d, c, 0, 0);
        2: op(1, 8'h61, d, c, 0, 0);
        3: op(1, 8'h62, d, c, 0, 0);
        4: op(1, 8'h80 | d, d, c, 0, 0);
        5: op(0, 0, 0, 0, 0, 1);
        default: op(0, 0, 0, 0, 1, 0);
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #1500000;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule